// File: doc/BRIEF.md
# SD Data-Phase Block Sequencer

This block runs the data phase of an SD card read or write. When a start strobe arrives with the data-phase enable set, it latches the direction, block size, block mode, block count and auto-stop choice. Then it counts the bytes that the data line engine reports, one strobe per byte. When a block's byte count is reached, the block is finished and the block counter steps down. When the final block finishes, the transfer completes. If auto-stop was requested, the block first asks the command path for a stop-transmission command and waits for the answer.

A CRC error, end-bit error or timeout from the data line engine stops the sequence at the current block. The number of blocks not yet moved is left visible, and the matching sticky flag is set. Errors from the automatic stop command go to a second group of sticky flags. That group also holds a not-executed flag for the case where a data error prevented the stop command from being issued. A separate data-path reset returns the sequencer to idle without touching the sticky flags.

States: IDLE (waiting for start), MOVE (counting bytes and blocks) and STOP (stop command requested). Transitions: IDLE→MOVE on an accepted start. MOVE→IDLE on a data error, or on the final block without auto-stop. MOVE→STOP on the final block with auto-stop. STOP→IDLE on `stop_ack`. Any state goes to IDLE on `dp_rst`.

Top module: `sd_xfer_seq`

## Requirements
- R1: A start is accepted only in IDLE, with `cfg_data_en`=1, a nonzero `cfg_blk_size`, and (in counted mode) a nonzero `cfg_blk_cnt`. Any other start leaves `dat_active` low and `blks_left` at 0.
- R2: Counted mode is `cfg_multi`=1 together with `cfg_cnt_en`=1, and it moves `cfg_blk_cnt` blocks. Every other combination of these two bits moves exactly one block. After an accepted start, `blks_left` shows this number.
- R3: A block ends on the `cfg_blk_size`-th `byte_stb`, for sizes 1 to 4095. `blks_left` drops by one in the cycle after each block ends.
- R4: `dat_active` and `dat_inhibit` are high from the cycle after an accepted start until the sequencer returns to IDLE.
- R5: With auto-stop, `stop_req` rises the cycle after the final byte. It stays high until `stop_ack`, and `xfer_done` sets the cycle after `stop_ack`.
- R6: Without auto-stop, `xfer_done` sets and `dat_active` drops the cycle after the final byte.
- R7: In MOVE, `dat_crc_in`, `dat_end_in` or `dat_tmo_in` ends the transfer the next cycle. The input sets `dat_crc_err`, `dat_end_err` or `dat_tmo` respectively, and `blks_left` then holds the unfinished blocks, current block included.
- R8: `stop_tmo`, `stop_crc_err` and `stop_end_err` take the values of `stop_tmo_in`, `stop_crc_in` and `stop_end_in` at `stop_ack`. `stop_ne` sets when a data error aborts a transfer that had auto-stop enabled.
- R9: All status flags are sticky. They are cleared only by the next accepted start.
- R10: `dp_rst` forces IDLE, `blks_left`=0 and the byte count to 0 in the next cycle, and leaves the status flags unchanged.
- R11: During a transfer, `xfer_read` shows the latched direction bit, where 1 means card-to-host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_rst | input | 1 | Synchronous data-path reset |
| start | input | 1 | Start strobe |
| cfg_data_en | input | 1 | Data phase present |
| cfg_read | input | 1 | Direction, 1 = card-to-host |
| cfg_multi | input | 1 | Multi-block select |
| cfg_cnt_en | input | 1 | Block-count enable |
| cfg_auto_stop | input | 1 | Request stop command after final block |
| cfg_blk_size | input | SIZE_W | Bytes per block |
| cfg_blk_cnt | input | CNT_W | Blocks in counted mode |
| byte_stb | input | 1 | One byte moved by the data line engine |
| dat_crc_in | input | 1 | Data CRC error from the engine |
| dat_end_in | input | 1 | Data end-bit error from the engine |
| dat_tmo_in | input | 1 | Data timeout from the engine |
| stop_req | output | 1 | Stop command request to the command path |
| stop_ack | input | 1 | Stop command finished |
| stop_tmo_in | input | 1 | Stop command timed out (valid with ack) |
| stop_crc_in | input | 1 | Stop command CRC error (valid with ack) |
| stop_end_in | input | 1 | Stop command end-bit error (valid with ack) |
| dat_active | output | 1 | Data line active |
| dat_inhibit | output | 1 | Data inhibit |
| xfer_read | output | 1 | Latched direction |
| blks_left | output | CNT_W | Blocks not yet transferred |
| xfer_done | output | 1 | Sticky transfer complete |
| dat_crc_err | output | 1 | Sticky data CRC error |
| dat_end_err | output | 1 | Sticky data end-bit error |
| dat_tmo | output | 1 | Sticky data timeout |
| stop_ne | output | 1 | Sticky stop command not executed |
| stop_tmo | output | 1 | Sticky stop command timeout |
| stop_crc_err | output | 1 | Sticky stop command CRC error |
| stop_end_err | output | 1 | Sticky stop command end-bit error |

## Verification
The sweep crosses four small block sizes, one to three blocks and all four combinations of the mode bits, each with and without auto-stop. This separates counted runs from single-block runs and exposes any off-by-one in the byte count. Single blocks of 512 and 4095 bytes cover the size range at its standard and largest values. A second sweep injects each of the three data errors into every block of a three-block run, with and without auto-stop. This tells the error kinds apart and checks both the remaining-block count and the not-executed flag. Directed cases cover rejected starts, a data-path reset mid-transfer, flags held while idle, and each stop-command error bit returned with the acknowledge.

// File: rtl/sd_seq_pkg.sv
package sd_seq_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_MOVE = 2'd1,
        S_STOP = 2'd2
    } seq_state_t;

    localparam int NFLAG   = 8;
    localparam int F_DONE  = 0;
    localparam int F_DCRC  = 1;
    localparam int F_DEND  = 2;
    localparam int F_DTMO  = 3;
    localparam int F_SNE   = 4;
    localparam int F_STMO  = 5;
    localparam int F_SCRC  = 6;
    localparam int F_SEND  = 7;
endpackage

// File: rtl/sd_byte_ctr.sv
module sd_byte_ctr #(
    parameter int SIZE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic [SIZE_W-1:0] size,
    output logic [SIZE_W-1:0] cnt,
    output logic              last
);
    localparam logic [SIZE_W-1:0] ONE = SIZE_W'(1);

    assign last = (cnt == size - ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clr)   cnt <= '0;
        else if (step)  cnt <= last ? '0 : cnt + ONE;
    end

    // R3
    byte_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (cnt < size));
endmodule

// File: rtl/sd_blk_ctr.sv
module sd_blk_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] left,
    output logic             last
);
    assign last = (left == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     left <= '0;
        else if (clr)   left <= '0;
        else if (load)  left <= load_val;
        else if (dec)   left <= left - CNT_W'(1);
    end

    // R3
    blk_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (left != '0));
endmodule

// File: rtl/sd_seq_flags.sv
module sd_seq_flags #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (clr)    flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/sd_xfer_seq.sv
module sd_xfer_seq
    import sd_seq_pkg::*;
#(
    parameter int SIZE_W = 12,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dp_rst,
    input  logic              start,
    input  logic              cfg_data_en,
    input  logic              cfg_read,
    input  logic              cfg_multi,
    input  logic              cfg_cnt_en,
    input  logic              cfg_auto_stop,
    input  logic [SIZE_W-1:0] cfg_blk_size,
    input  logic [CNT_W-1:0]  cfg_blk_cnt,
    input  logic              byte_stb,
    input  logic              dat_crc_in,
    input  logic              dat_end_in,
    input  logic              dat_tmo_in,
    output logic              stop_req,
    input  logic              stop_ack,
    input  logic              stop_tmo_in,
    input  logic              stop_crc_in,
    input  logic              stop_end_in,
    output logic              dat_active,
    output logic              dat_inhibit,
    output logic              xfer_read,
    output logic [CNT_W-1:0]  blks_left,
    output logic              xfer_done,
    output logic              dat_crc_err,
    output logic              dat_end_err,
    output logic              dat_tmo,
    output logic              stop_ne,
    output logic              stop_tmo,
    output logic              stop_crc_err,
    output logic              stop_end_err
);
    seq_state_t        state, nxt;
    logic [SIZE_W-1:0] size_r;
    logic              auto_r;
    logic [SIZE_W-1:0] byte_cnt;
    logic              byte_last, blk_last;
    logic [NFLAG-1:0]  fset, flags;

    logic counted, accept, in_move, err_any, step, blk_fin, stop_ok;

    assign counted = cfg_multi & cfg_cnt_en;
    assign accept  = (state == S_IDLE) && start && cfg_data_en &&
                     (cfg_blk_size != '0) && !(counted && (cfg_blk_cnt == '0));
    assign in_move = (state == S_MOVE);
    assign err_any = in_move && (dat_crc_in || dat_end_in || dat_tmo_in);
    assign step    = in_move && !err_any && byte_stb;
    assign blk_fin = step && byte_last;
    assign stop_ok = (state == S_STOP) && stop_ack;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (accept) nxt = S_MOVE;
            S_MOVE: begin
                if (err_any)                   nxt = S_IDLE;
                else if (blk_fin && blk_last)  nxt = auto_r ? S_STOP : S_IDLE;
            end
            S_STOP: if (stop_ack) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state <= S_IDLE;
        else if (dp_rst) state <= S_IDLE;
        else             state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_active  <= 1'b0;
            dat_inhibit <= 1'b0;
            stop_req    <= 1'b0;
            xfer_read   <= 1'b0;
            size_r      <= '0;
            auto_r      <= 1'b0;
        end else begin
            dat_active  <= !dp_rst && (nxt != S_IDLE);
            dat_inhibit <= !dp_rst && (nxt != S_IDLE);
            stop_req    <= !dp_rst && (nxt == S_STOP);
            if (accept) begin
                xfer_read <= cfg_read;
                size_r    <= cfg_blk_size;
                auto_r    <= cfg_auto_stop;
            end
        end
    end

    always_comb begin
        fset         = '0;
        fset[F_DONE] = (blk_fin && blk_last && !auto_r) || stop_ok;
        fset[F_DCRC] = in_move && dat_crc_in;
        fset[F_DEND] = in_move && dat_end_in;
        fset[F_DTMO] = in_move && dat_tmo_in;
        fset[F_SNE]  = err_any && auto_r;
        fset[F_STMO] = stop_ok && stop_tmo_in;
        fset[F_SCRC] = stop_ok && stop_crc_in;
        fset[F_SEND] = stop_ok && stop_end_in;
    end

    sd_byte_ctr #(.SIZE_W(SIZE_W)) u_byte (
        .clk(clk), .rst_n(rst_n), .clr(accept || dp_rst), .step(step),
        .size(size_r), .cnt(byte_cnt), .last(byte_last)
    );

    sd_blk_ctr #(.CNT_W(CNT_W)) u_blk (
        .clk(clk), .rst_n(rst_n), .clr(dp_rst), .load(accept),
        .load_val(counted ? cfg_blk_cnt : CNT_W'(1)), .dec(blk_fin && !dp_rst),
        .left(blks_left), .last(blk_last)
    );

    sd_seq_flags #(.N(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .clr(accept), .set(fset), .flags(flags)
    );

    assign xfer_done    = flags[F_DONE];
    assign dat_crc_err  = flags[F_DCRC];
    assign dat_end_err  = flags[F_DEND];
    assign dat_tmo      = flags[F_DTMO];
    assign stop_ne      = flags[F_SNE];
    assign stop_tmo     = flags[F_STMO];
    assign stop_crc_err = flags[F_SCRC];
    assign stop_end_err = flags[F_SEND];

    // R10
    dp_rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_rst |=> (!dat_active && blks_left == '0 && byte_cnt == '0));
    // R5
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !stop_ack && !dp_rst) |=> stop_req);
    // R5
    stop_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_req) |-> (blks_left == '0));
    // R7
    err_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dat_crc_err) || $rose(dat_end_err) || $rose(dat_tmo)) |->
            (blks_left != '0 && !dat_active));
    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> (!dat_active && !stop_req));
endmodule

// File: tb/sd_xfer_seq_tb.sv
`timescale 1ns/1ps
module sd_xfer_seq_tb;
    localparam int SIZE_W = 12;
    localparam int CNT_W  = 16;

    logic clk = 1'b0, rst_n = 1'b0, dp_rst = 1'b0, start = 1'b0;
    logic cfg_data_en = 1'b0, cfg_read = 1'b0, cfg_multi = 1'b0, cfg_cnt_en = 1'b0, cfg_auto_stop = 1'b0;
    logic [SIZE_W-1:0] cfg_blk_size = '0;
    logic [CNT_W-1:0]  cfg_blk_cnt = '0;
    logic byte_stb = 1'b0, dat_crc_in = 1'b0, dat_end_in = 1'b0, dat_tmo_in = 1'b0;
    logic stop_ack = 1'b0, stop_tmo_in = 1'b0, stop_crc_in = 1'b0, stop_end_in = 1'b0;
    logic stop_req, dat_active, dat_inhibit, xfer_read, xfer_done;
    logic dat_crc_err, dat_end_err, dat_tmo, stop_ne, stop_tmo, stop_crc_err, stop_end_err;
    logic [CNT_W-1:0] blks_left;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sd_xfer_seq #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] flagv();
        return {stop_end_err, stop_crc_err, stop_tmo, stop_ne, dat_tmo, dat_end_err, dat_crc_err, xfer_done};
    endfunction

    task automatic kick(int size, int cnt, bit multi, bit cnten, bit auto_s, bit rd);
        cfg_data_en = 1'b1; cfg_blk_size = SIZE_W'(size); cfg_blk_cnt = CNT_W'(cnt);
        cfg_multi = multi; cfg_cnt_en = cnten; cfg_auto_stop = auto_s; cfg_read = rd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // errtype 0 none, 1 crc, 2 end-bit, 3 timeout
    task automatic run(int size, int cnt, bit multi, bit cnten, bit auto_s, bit rd,
                       int errblk, int errtype, logic [2:0] serr);
        int expn;
        expn = (multi && cnten) ? cnt : 1;
        kick(size, cnt, multi, cnten, auto_s, rd);
        chk("R2 blocks loaded", blks_left, expn);
        chk("R4 active", {dat_active, dat_inhibit}, 2'b11);
        chk("R11 direction", xfer_read, rd);
        chk("R9 flags cleared by start", flagv(), 8'h00);
        for (int b = 0; b < expn; b++) begin
            for (int by = 0; by < size; by++) begin
                if (b == errblk && by == size / 2) begin
                    byte_stb = 1'b0;
                    dat_crc_in = (errtype == 1); dat_end_in = (errtype == 2); dat_tmo_in = (errtype == 3);
                    @(negedge clk);
                    dat_crc_in = 1'b0; dat_end_in = 1'b0; dat_tmo_in = 1'b0;
                    chk("R7 error flags", {dat_tmo, dat_end_err, dat_crc_err},
                        {errtype == 3, errtype == 2, errtype == 1});
                    chk("R7 blocks left", blks_left, expn - b);
                    chk("R7 stopped", {dat_active, stop_req, xfer_done}, 3'b000);
                    chk("R8 not executed", stop_ne, auto_s);
                    return;
                end
                byte_stb = 1'b1;
                @(negedge clk);
            end
            byte_stb = 1'b0;
            if (b < expn - 1) begin
                chk("R3 block count step", blks_left, expn - b - 1);
                @(negedge clk);
                chk("R3 idle gap holds", blks_left, expn - b - 1);
            end
        end
        chk("R3 all blocks", blks_left, 0);
        if (auto_s) begin
            chk("R5 stop requested", {stop_req, xfer_done, dat_active}, 3'b101);
            @(negedge clk); @(negedge clk);
            chk("R5 stop held", {stop_req, xfer_done}, 2'b10);
            stop_ack = 1'b1; {stop_end_in, stop_crc_in, stop_tmo_in} = serr;
            @(negedge clk);
            stop_ack = 1'b0; {stop_end_in, stop_crc_in, stop_tmo_in} = 3'b000;
            chk("R5 done after ack", {xfer_done, stop_req, dat_active}, 3'b100);
            chk("R8 stop errors", {stop_end_err, stop_crc_err, stop_tmo}, serr);
        end else begin
            chk("R6 done", {xfer_done, dat_active, stop_req}, 3'b100);
        end
    endtask

    initial begin
        #1600000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 reset idle", {dat_active, dat_inhibit, stop_req}, 3'b000);
        chk("R9 reset flags", flagv(), 8'h00);

        // R1: rejected starts
        cfg_data_en = 1'b0; cfg_blk_size = 12'd4; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R1 no data phase ignored", {dat_active, 15'(blks_left)}, 16'h0);
        kick(4, 0, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R1 zero count ignored", {dat_active, 15'(blks_left)}, 16'h0);
        kick(0, 2, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R1 zero size ignored", {dat_active, 15'(blks_left)}, 16'h0);

        // R2/R3/R5/R6 sweep
        for (int si = 0; si < 4; si++) begin
            for (int c = 1; c <= 3; c++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int a = 0; a < 2; a++) begin
                        int sz;
                        sz = (si == 3) ? 7 : si + 1;
                        run(sz, c, m[1], m[0], a[0], n[0], -1, 0, 3'(n));
                        n++;
                        @(negedge clk);
                    end
                end
            end
        end

        // R3 boundary sizes
        run(512, 1, 1'b0, 1'b0, 1'b0, 1'b1, -1, 0, 3'b000);
        run(4095, 1, 1'b0, 1'b0, 1'b1, 1'b0, -1, 0, 3'b111);

        // R9 sticky while idle
        repeat (4) @(negedge clk);
        chk("R9 flags held", flagv(), 8'he1);

        // R7/R8 error sweep
        for (int e = 1; e <= 3; e++)
            for (int eb = 0; eb < 3; eb++)
                for (int a = 0; a < 2; a++) begin
                    run(3, 3, 1'b1, 1'b1, a[0], 1'b1, eb, e, 3'b000);
                    repeat (2) @(negedge clk);
                    chk("R9 error flag held", {dat_tmo, dat_end_err, dat_crc_err},
                        {e == 3, e == 2, e == 1});
                end

        // R10 data-path reset mid transfer
        kick(5, 3, 1'b1, 1'b1, 1'b1, 1'b0);
        byte_stb = 1'b1; repeat (7) @(negedge clk); byte_stb = 1'b0;
        chk("R10 before reset", blks_left, 2);
        dp_rst = 1'b1; @(negedge clk); dp_rst = 1'b0;
        chk("R10 cleared", {dat_active, dat_inhibit, stop_req, 16'(blks_left)}, 19'h0);
        chk("R10 flags untouched", flagv(), 8'h00);
        run(2, 1, 1'b0, 1'b0, 1'b0, 1'b0, -1, 0, 3'b000);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule